// File: doc/BRIEF.md
# Discrete Loop-Back Test Multiplexer

This block lets a host test its own discrete output lines when it has fewer input lines than outputs. The outputs are split into groups of eight. A command written over the host's serial data bus picks one group, and the block sends that group back on the host's eight input discrete lines. The host then compares what it reads with what it drove.

A select register holds the chosen group. A write puts a new value in it when the write's address matches a fixed select address, and only the low bits of the data word are used. The register resets to the first group (code 0). The returned lines follow the group inputs combinationally through a mux, so a change on a selected group shows up in the same cycle.

To protect the host, nothing is returned until the host's supply is seen as good. The raw power-good input passes through a synchronizer. The synchronized level must then stay high for a set number of consecutive clocks before the outputs are enabled. While they are not enabled, the eight lines are held at zero and the output-enable is low. A single low sample at the synchronizer output disables them at once, and qualification then starts again from the beginning.

Top module: `discrete_loopback_mux`

## Requirements
- R1: After reset the select register holds code 0 (the first group, bits 7:0 of `grp_in`), `ret_oe` is 0 and `ret_lines` is all zero.
- R2: A cycle with `wr_valid` high and `wr_addr` equal to `SEL_ADDR` (default 16'h0031) loads `wr_data[1:0]` into the select register at that clock edge. The new group appears on `ret_lines` right after that edge.
- R3: The select register keeps its value when a write goes to any other address, and when `wr_valid` is low, whatever `wr_data` holds.
- R4: While `ret_oe` is high, `ret_lines` equals `grp_in[8*s +: 8]` for select code s. It follows changes on `grp_in` in the same cycle, with no register in between.
- R5: `ret_oe` rises after the 18th consecutive rising clock edge that samples `pwr_good_raw` high: two synchronizer stages plus 16 qualifying clocks. It stays low after every earlier edge.
- R6: Once `pwr_good_raw` is sampled low, `ret_oe` is low after the second clock edge. A later rise must then qualify in full again, as in R5.
- R7: While `ret_oe` is low, `ret_lines` is all zero whatever `grp_in` and the select register hold.
- R8: `wr_ready` is always high. The select write port never applies back-pressure, and every valid beat is taken in the cycle it is offered.
- R9: Bits of `wr_data` above bit 1 have no effect on which group is returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Select write beat offered |
| wr_ready | output | 1 | Select write beat accepted (always 1) |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data; low 2 bits are the group code |
| grp_in | input | 32 | Four 8-bit output-discrete groups, group code g at bits 8g+7:8g |
| pwr_good_raw | input | 1 | Asynchronous host power-good indication |
| ret_lines | output | 8 | Returned input discrete lines |
| ret_oe | output | 1 | Return output enable |

## Verification
The bench builds the block with its default parameters: four groups of eight lines, a 16-clock qualification window, two synchronizer stages and select address 16'h0031. With these values every group code is reachable from a 2-bit write field. The full 18-edge power-up window and the two-edge drop latency are short enough to test many times, both directly and inside random power glitches. Random writes aimed at the select address and at nearby addresses, with junk in the upper data bits, exercise loading, ignored writes and the same-cycle path from the group inputs together.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

  typedef enum logic [1:0] {
    PQ_OFF = 2'd0,
    PQ_ARM = 2'd1,
    PQ_ON  = 2'd2
  } pq_state_e;

  function automatic int unsigned sel_width(input int unsigned groups);
    return (groups > 1) ? $clog2(groups) : 1;
  endfunction

endpackage

// File: rtl/dlb_pwr_qual.sv
module dlb_pwr_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_raw,
  output logic pg_ok
);
  import dlb_pkg::*;

  localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pg_s;
  pq_state_e              state_q;
  logic [CNT_W-1:0]       cnt_q;

  // synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pg_raw;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pg_raw};
      end
    end
  endgenerate

  assign pg_s = sync_q[SYNC_STAGES-1];

  // qualification: count consecutive synchronized-high clocks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PQ_OFF;
      cnt_q   <= '0;
    end else if (!pg_s) begin
      state_q <= PQ_OFF;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PQ_OFF: begin
          cnt_q   <= CNT_W'(1);
          state_q <= (CNT_LAST == CNT_W'(1)) ? PQ_ON : PQ_ARM;
        end
        PQ_ARM: begin
          cnt_q   <= cnt_q + CNT_W'(1);
          state_q <= (cnt_q + CNT_W'(1) == CNT_LAST) ? PQ_ON : PQ_ARM;
        end
        PQ_ON: begin
          cnt_q   <= cnt_q;
          state_q <= PQ_ON;
        end
        default: begin
          cnt_q   <= '0;
          state_q <= PQ_OFF;
        end
      endcase
    end
  end

  // a low synchronized sample cuts the enable with no extra delay
  assign pg_ok = (state_q == PQ_ON) && pg_s;

endmodule

// File: rtl/dlb_sel_reg.sv
module dlb_sel_reg #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SEL_W     = 2,
  parameter logic [15:0] SEL_ADDR  = 16'h0031,
  parameter int unsigned RESET_SEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel
);

  logic hit;
  logic data_unused;

  assign hit = wr_valid && (wr_addr == ADDR_W'(SEL_ADDR));

  generate
    if (DATA_W > SEL_W) begin : g_hi
      assign data_unused = ^wr_data[DATA_W-1:SEL_W];
    end else begin : g_nohi
      assign data_unused = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)   sel <= SEL_W'(RESET_SEL);
    else if (hit) sel <= wr_data[SEL_W-1:0];
  end

endmodule

// File: rtl/dlb_group_mux.sv
module dlb_group_mux #(
  parameter int unsigned GROUPS = 4,
  parameter int unsigned LINE_W = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [GROUPS*LINE_W-1:0] grp,
  input  logic [SEL_W-1:0]         sel,
  input  logic                     en,
  output logic [LINE_W-1:0]        lines
);

  logic [LINE_W-1:0] masked [GROUPS];
  logic [LINE_W-1:0] merged;

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic hit;
      assign hit       = (sel == SEL_W'(g));
      assign masked[g] = hit ? grp[g*LINE_W +: LINE_W] : '0;
    end
  endgenerate

  always_comb begin
    merged = '0;
    for (int i = 0; i < GROUPS; i++) merged = merged | masked[i];
  end

  assign lines = en ? merged : '0;

endmodule

// File: rtl/discrete_loopback_mux.sv
module discrete_loopback_mux #(
  parameter int unsigned GROUPS      = 4,
  parameter int unsigned LINE_W      = 8,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter logic [15:0] SEL_ADDR    = 16'h0031,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYCLES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [GROUPS*LINE_W-1:0] grp_in,
  input  logic                     pwr_good_raw,
  output logic [LINE_W-1:0]        ret_lines,
  output logic                     ret_oe
);
  localparam int unsigned SEL_W = dlb_pkg::sel_width(GROUPS);

  logic [SEL_W-1:0] sel_q;
  logic             pg_ok;

  assign wr_ready = 1'b1;

  dlb_sel_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .SEL_ADDR(SEL_ADDR), .RESET_SEL(0)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .sel(sel_q)
  );

  dlb_pwr_qual #(
    .SYNC_STAGES(SYNC_STAGES), .QUAL_CYCLES(QUAL_CYCLES)
  ) u_pq (
    .clk(clk), .rst_n(rst_n), .pg_raw(pwr_good_raw), .pg_ok(pg_ok)
  );

  dlb_group_mux #(
    .GROUPS(GROUPS), .LINE_W(LINE_W), .SEL_W(SEL_W)
  ) u_mux (
    .grp(grp_in), .sel(sel_q), .en(pg_ok), .lines(ret_lines)
  );

  assign ret_oe = pg_ok;

endmodule

// File: rtl/dlb_chk.sv
module dlb_chk #(
  parameter int unsigned GROUPS      = 4,
  parameter int unsigned LINE_W      = 8,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter logic [15:0] SEL_ADDR    = 16'h0031,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYCLES = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_valid,
  input logic                     wr_ready,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [DATA_W-1:0]        wr_data,
  input logic [GROUPS*LINE_W-1:0] grp_in,
  input logic                     pwr_good_raw,
  input logic [LINE_W-1:0]        ret_lines,
  input logic                     ret_oe
);
  localparam int unsigned SEL_W    = dlb_pkg::sel_width(GROUPS);
  localparam int unsigned RUN_NEED = SYNC_STAGES + QUAL_CYCLES - 1;
  localparam int unsigned RUN_W    = $clog2(RUN_NEED + 2);

  logic [RUN_W-1:0] hi_run, lo_run;
  logic             sel_hit;

  assign sel_hit = wr_valid && wr_ready && (wr_addr == ADDR_W'(SEL_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= !pwr_good_raw ? '0 : (hi_run >= RUN_W'(RUN_NEED)) ? hi_run : hi_run + RUN_W'(1);
      lo_run <= pwr_good_raw  ? '0 : (lo_run >= RUN_W'(SYNC_STAGES)) ? lo_run : lo_run + RUN_W'(1);
    end
  end

  function automatic logic [LINE_W-1:0] pick(input logic [GROUPS*LINE_W-1:0] g,
                                             input logic [SEL_W-1:0] s);
    return g[s*LINE_W +: LINE_W];
  endfunction

  // R7
  blank_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_oe |-> (ret_lines == '0));

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |=> (!ret_oe || ret_lines == pick(grp_in, $past(wr_data[SEL_W-1:0]))));

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_hit && ret_oe) |=> (!ret_oe || !$stable(grp_in) || $stable(ret_lines)));

  // R5
  qual_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_oe) |-> ($past(hi_run) >= RUN_W'(RUN_NEED)));

  // R6
  drop_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_run >= RUN_W'(SYNC_STAGES)) |-> !ret_oe);

endmodule

bind discrete_loopback_mux dlb_chk #(
  .GROUPS(GROUPS), .LINE_W(LINE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .SEL_ADDR(SEL_ADDR), .SYNC_STAGES(SYNC_STAGES), .QUAL_CYCLES(QUAL_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .grp_in(grp_in),
  .pwr_good_raw(pwr_good_raw), .ret_lines(ret_lines), .ret_oe(ret_oe)
);

// File: tb/discrete_loopback_mux_bench.sv
module discrete_loopback_mux_bench;
  localparam logic [15:0] SADDR = 16'h0031;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] grp_in = '0;
  logic        pwr_good_raw = 1'b0;
  logic [7:0]  ret_lines;
  logic        ret_oe;

  int total = 0;
  int bad   = 0;
  logic [1:0]  m_sel  = 2'd0;
  logic [17:0] m_hist = '0;

  always #4 clk = ~clk;

  discrete_loopback_mux u_discrete_loopback_mux (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .grp_in(grp_in),
    .pwr_good_raw(pwr_good_raw), .ret_lines(ret_lines), .ret_oe(ret_oe)
  );

  function automatic logic exp_oe(input logic [17:0] h);
    return &h[17:1];
  endfunction

  function automatic logic [7:0] exp_lines(input logic [31:0] g, input logic [1:0] s,
                                           input logic oe);
    return oe ? g[s*8 +: 8] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one clock: drive at negedge, update model at the edge, sample 2 ns later
  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] d,
                      input logic [31:0] g, input logic p);
    logic eo;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; grp_in = g; pwr_good_raw = p;
    @(posedge clk);
    if (v && a == SADDR) m_sel = d[1:0];
    m_hist = {m_hist[16:0], p};
    #2;
    eo = exp_oe(m_hist);
    chk(eo ? "R5" : "R6", {31'd0, ret_oe}, {31'd0, eo});
    chk(eo ? "R4" : "R7", {24'd0, ret_lines}, {24'd0, exp_lines(g, m_sel, eo)});
    chk("R8", {31'd0, wr_ready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int n;
    logic [31:0] gpat;
    void'($urandom(32'd4242));
    gpat = 32'hA4B3C2D1;
    grp_in = gpat;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1", {31'd0, ret_oe}, 32'd0);
    chk("R1", {24'd0, ret_lines}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R5: count edges until enable
    n = 0;
    for (int i = 1; i <= 30; i++) begin
      step(1'b0, 16'h0, 16'h0, gpat, 1'b1);
      if (ret_oe && n == 0) n = i;
    end
    chk("R5", n, 18);
    chk("R1", {24'd0, ret_lines}, 32'hD1);

    // R2 and R9: junk upper bits, code 2
    step(1'b1, SADDR, 16'hFFF6, gpat, 1'b1);
    chk("R9", {24'd0, ret_lines}, 32'hB3);
    // R3: other address, then valid low
    step(1'b1, 16'h0030, 16'h0003, gpat, 1'b1);
    chk("R3", {24'd0, ret_lines}, 32'hB3);
    step(1'b0, SADDR, 16'h0003, gpat, 1'b1);
    chk("R3", {24'd0, ret_lines}, 32'hB3);
    // R4: same-cycle follow
    step(1'b0, 16'h0, 16'h0, 32'h005A0000, 1'b1);
    chk("R4", {24'd0, ret_lines}, 32'h5A);
    step(1'b1, SADDR, 16'h0003, gpat, 1'b1);
    chk("R2", {24'd0, ret_lines}, 32'hA4);

    // R6: single-cycle glitch, then full requalification
    step(1'b0, 16'h0, 16'h0, gpat, 1'b0);
    chk("R6", {31'd0, ret_oe}, 32'd1);
    step(1'b0, 16'h0, 16'h0, gpat, 1'b1);
    chk("R6", {31'd0, ret_oe}, 32'd0);
    chk("R7", {24'd0, ret_lines}, 32'd0);
    n = 0;
    for (int i = 2; i <= 30; i++) begin
      step(1'b0, 16'h0, 16'h0, gpat, 1'b1);
      if (ret_oe && n == 0) n = i;
    end
    chk("R6", n, 18);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic        v, p;
      logic [15:0] a;
      v = ($urandom % 3) == 0;
      a = (($urandom % 2) == 0) ? SADDR : (SADDR ^ 16'($urandom % 4 + 1));
      p = ($urandom % 48) != 0;
      step(v, a, 16'($urandom), $urandom, p);
    end

    summary();
  end

endmodule